// File: doc/BRIEF.md
# Power-up strap latch and test-mode selector

This block takes a snapshot of the configuration straps on the first clock edge at which the power-good input is seen high, and keeps that snapshot until the next power cycle. In this design a power cycle is an assertion of `rst_n`. Some pins are shared between straps and outputs. From the held values the block drives their function selects, and it gives software a readback of the frequency-select bits and the straps.

The block also decides how the outputs behave in test mode. The three-level select input arrives already decoded as a 2-bit code. A high reading at capture puts the device into hardware test mode, and the live mode pin then chooses between high impedance and a divided reference. Without hardware test mode, software can pulse an entry bit to reach test mode. Its select bit then makes the same choice and the mode pin is ignored. Test mode, once reached, is left only by a power cycle.

All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `strap_capture_top`

## Requirements
- R1: From reset until the first clock edge that samples `pwr_good` high, `mode_code` is 0 (not ready). Over the same interval every readback and function-select output is 0, whatever the other inputs do.
- R2: At the first edge sampling `pwr_good` high, the block captures `fs_readback = {fsc, fs_plain}`, `strap_pair_rb` and `strap_dbg_rb`. The values are visible after that edge. Here `fsc` is 1 only for `sel3_code` 2'b01. Later changes of the straps or of `pwr_good` leave them unchanged until `rst_n` is asserted.
- R3: After capture, a held pair strap of 0 gives `pair_stop_fn`=1 and `pair_clk_fn`=0. A value of 1 gives the reverse.
- R4: After capture, a held debug strap of 1 gives `dbg_clk_fn`=1 and `gen_clk_fn`=0. A value of 0 gives the reverse.
- R5: A `sel3_code` of 2'b1x at capture enters hardware test mode and reads back `fsc`=0. A code of 2'b00 or 2'b01 gives normal operation, with `mode_code` equal to 1.
- R6: In hardware test mode, `mode_code` follows `test_mode_pin` in the same cycle: 1 gives 3 (reference divided) and 0 gives 2 (high impedance). The software bits have no effect.
- R7: Consider an edge after capture, with hardware test mode not latched, that samples `sw_test_entry` high. From that edge on, `mode_code` is 3 when `sw_test_sel` is 1 and 2 when it is 0, following `sw_test_sel` live. `test_mode_pin` is ignored.
- R8: Software test mode stays in force after `sw_test_entry` returns to 0, until `rst_n` is asserted.
- R9: A `sw_test_entry` pulse before capture, or in the capture cycle itself, has no effect. After capture `mode_code` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-cycle reset |
| pwr_good | input | 1 | Power-good level; first high sample triggers capture |
| sel3_code | input | 2 | Decoded three-level select: 00 low, 01 mid, 1x high |
| fs_plain | input | FS_PLAIN_W | Two-level frequency-select straps |
| strap_pair | input | 1 | Strap choosing clock (1) or stop inputs (0) for the shared pair |
| strap_dbg | input | 1 | Strap choosing debug clock (1) or generic clock (0) |
| test_mode_pin | input | 1 | Live hardware test-mode select |
| sw_test_entry | input | 1 | Software test-entry bit |
| sw_test_sel | input | 1 | Software test select: 1 reference divided, 0 high impedance |
| fs_readback | output | FS_PLAIN_W+1 | Held frequency-select bits {fsc, fs_plain} |
| strap_pair_rb | output | 1 | Held pair strap |
| strap_dbg_rb | output | 1 | Held debug strap |
| pair_stop_fn | output | 1 | Shared pair acts as stop inputs |
| pair_clk_fn | output | 1 | Shared pair acts as a clock output |
| dbg_clk_fn | output | 1 | Second pair acts as debug clock |
| gen_clk_fn | output | 1 | Second pair acts as generic clock |
| mode_code | output | 2 | 0 not ready, 1 normal, 2 high impedance, 3 reference divided |

## Verification
Captured values and function selects become visible one edge after `pwr_good` is first sampled high. A software entry changes `mode_code` one edge after it is sampled. `test_mode_pin` and `sw_test_sel` act on `mode_code` in the same cycle, with no register in between. The bench changes inputs on the falling edge and samples 5 ns after the rising edge. A reference model is advanced at that rising edge with the inputs the design saw, so the registered results and the combinational results are both compared in the cycle they are due.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef enum logic [1:0] {
    MODE_NOTREADY = 2'd0,
    MODE_NORMAL   = 2'd1,
    MODE_HIZ      = 2'd2,
    MODE_REFDIV   = 2'd3
  } tmode_e;

  function automatic logic sel3_high(input logic [1:0] code);
    return code[1];
  endfunction

  function automatic logic sel3_fs_bit(input logic [1:0] code);
    return (code == 2'b01);
  endfunction
endpackage

// File: rtl/strap_latch.sv
module strap_latch
  import strap_pkg::*;
#(
  parameter int FS_PLAIN_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwr_good,
  input  logic [1:0]            sel3_code,
  input  logic [FS_PLAIN_W-1:0] fs_plain,
  input  logic                  strap_pair,
  input  logic                  strap_dbg,
  output logic                  valid,
  output logic [FS_PLAIN_W:0]   fs_q,
  output logic                  pair_q,
  output logic                  dbg_q,
  output logic                  hw_test
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      fs_q    <= '0;
      pair_q  <= 1'b0;
      dbg_q   <= 1'b0;
      hw_test <= 1'b0;
    end else if (pwr_good && !valid) begin
      valid   <= 1'b1;
      fs_q    <= {sel3_fs_bit(sel3_code), fs_plain};
      pair_q  <= strap_pair;
      dbg_q   <= strap_dbg;
      hw_test <= sel3_high(sel3_code);
    end
  end

  // R2: once captured, nothing moves until the next power cycle
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid && $stable(fs_q) && $stable(pair_q) && $stable(dbg_q) && $stable(hw_test));

  // R1: no capture and no change while power-good is still low
  assert_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !pwr_good) |=> (!valid && fs_q == '0 && !pair_q && !dbg_q && !hw_test));
endmodule

// File: rtl/pin_func_map.sv
module pin_func_map #(
  parameter int N_STRAP = 2
) (
  input  logic               valid,
  input  logic [N_STRAP-1:0] strap_q,
  output logic [N_STRAP-1:0] fn_one,
  output logic [N_STRAP-1:0] fn_zero
);
  for (genvar i = 0; i < N_STRAP; i++) begin : g_map
    assign fn_one[i]  = valid &  strap_q[i];
    assign fn_zero[i] = valid & ~strap_q[i];
  end
endmodule

// File: rtl/test_mode_ctrl.sv
module test_mode_ctrl
  import strap_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   valid,
  input  logic   hw_test,
  input  logic   mode_pin,
  input  logic   sw_entry,
  input  logic   sw_sel,
  output tmode_e mode,
  output logic   sw_test
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sw_test <= 1'b0;
    else if (valid && !hw_test && sw_entry)
      sw_test <= 1'b1;
  end

  always_comb begin
    if (!valid)
      mode = MODE_NOTREADY;
    else if (hw_test)
      mode = mode_pin ? MODE_REFDIV : MODE_HIZ;
    else if (sw_test)
      mode = sw_sel ? MODE_REFDIV : MODE_HIZ;
    else
      mode = MODE_NORMAL;
  end

  // R8: software test mode is one-shot and sticky
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_test |=> sw_test);

  // R7: the software path never engages over a latched hardware test mode
  assert_hw_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_test |-> !sw_test);

  // R9: no software entry before capture
  assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !sw_test);
endmodule

// File: rtl/strap_capture_top.sv
module strap_capture_top
  import strap_pkg::*;
#(
  parameter int FS_PLAIN_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwr_good,
  input  logic [1:0]            sel3_code,
  input  logic [FS_PLAIN_W-1:0] fs_plain,
  input  logic                  strap_pair,
  input  logic                  strap_dbg,
  input  logic                  test_mode_pin,
  input  logic                  sw_test_entry,
  input  logic                  sw_test_sel,
  output logic [FS_PLAIN_W:0]   fs_readback,
  output logic                  strap_pair_rb,
  output logic                  strap_dbg_rb,
  output logic                  pair_stop_fn,
  output logic                  pair_clk_fn,
  output logic                  dbg_clk_fn,
  output logic                  gen_clk_fn,
  output logic [1:0]            mode_code
);
  localparam int N_STRAP = 2;

  logic               valid, hw_test, sw_test;
  logic [N_STRAP-1:0] fn_one, fn_zero;
  tmode_e             mode;

  strap_latch #(.FS_PLAIN_W(FS_PLAIN_W)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .sel3_code  (sel3_code),
    .fs_plain   (fs_plain),
    .strap_pair (strap_pair),
    .strap_dbg  (strap_dbg),
    .valid      (valid),
    .fs_q       (fs_readback),
    .pair_q     (strap_pair_rb),
    .dbg_q      (strap_dbg_rb),
    .hw_test    (hw_test)
  );

  pin_func_map #(.N_STRAP(N_STRAP)) u_map (
    .valid   (valid),
    .strap_q ({strap_dbg_rb, strap_pair_rb}),
    .fn_one  (fn_one),
    .fn_zero (fn_zero)
  );

  assign pair_clk_fn  = fn_one[0];
  assign pair_stop_fn = fn_zero[0];
  assign dbg_clk_fn   = fn_one[1];
  assign gen_clk_fn   = fn_zero[1];

  test_mode_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (valid),
    .hw_test  (hw_test),
    .mode_pin (test_mode_pin),
    .sw_entry (sw_test_entry),
    .sw_sel   (sw_test_sel),
    .mode     (mode),
    .sw_test  (sw_test)
  );

  assign mode_code = mode;

  // R3: once captured, the shared pair has exactly one function
  assert_pair_fn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (pair_stop_fn != pair_clk_fn));

  // R4: once captured, the second pair has exactly one function
  assert_dbg_fn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (dbg_clk_fn != gen_clk_fn));

  // R1: not-ready mode keeps every pin function off
  assert_notready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'd0) |-> !(pair_stop_fn | pair_clk_fn | dbg_clk_fn | gen_clk_fn));
endmodule

// File: tb/strap_capture_top_bench.sv
module strap_capture_top_bench;
  localparam int W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0;
  logic [1:0] sel3_code = 2'b00;
  logic [W-1:0] fs_plain = '0;
  logic strap_pair = 1'b0, strap_dbg = 1'b0;
  logic test_mode_pin = 1'b0, sw_test_entry = 1'b0, sw_test_sel = 1'b0;
  logic [W:0] fs_readback;
  logic strap_pair_rb, strap_dbg_rb, pair_stop_fn, pair_clk_fn, dbg_clk_fn, gen_clk_fn;
  logic [1:0] mode_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  bit m_valid, m_hw, m_sw, m_pair, m_dbg;
  logic [W:0] m_fs;

  always #10 clk = ~clk;

  strap_capture_top #(.FS_PLAIN_W(W)) u_strap_capture_top (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sel3_code(sel3_code),
    .fs_plain(fs_plain), .strap_pair(strap_pair), .strap_dbg(strap_dbg),
    .test_mode_pin(test_mode_pin), .sw_test_entry(sw_test_entry), .sw_test_sel(sw_test_sel),
    .fs_readback(fs_readback), .strap_pair_rb(strap_pair_rb), .strap_dbg_rb(strap_dbg_rb),
    .pair_stop_fn(pair_stop_fn), .pair_clk_fn(pair_clk_fn), .dbg_clk_fn(dbg_clk_fn),
    .gen_clk_fn(gen_clk_fn), .mode_code(mode_code)
  );

  function automatic logic [1:0] exp_mode();
    if (!m_valid) return 2'd0;
    if (m_hw) return test_mode_pin ? 2'd3 : 2'd2;
    if (m_sw) return sw_test_sel ? 2'd3 : 2'd2;
    return 2'd1;
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "fs_readback", 8'(fs_readback), 8'(m_valid ? m_fs : '0));
    chk(tag, "strap_pair_rb", 8'(strap_pair_rb), 8'(m_valid & m_pair));
    chk(tag, "strap_dbg_rb", 8'(strap_dbg_rb), 8'(m_valid & m_dbg));
    chk(tag, "pair_stop_fn", 8'(pair_stop_fn), 8'(m_valid & ~m_pair));
    chk(tag, "pair_clk_fn", 8'(pair_clk_fn), 8'(m_valid & m_pair));
    chk(tag, "dbg_clk_fn", 8'(dbg_clk_fn), 8'(m_valid & m_dbg));
    chk(tag, "gen_clk_fn", 8'(gen_clk_fn), 8'(m_valid & ~m_dbg));
    chk(tag, "mode_code", 8'(mode_code), 8'(exp_mode()));
  endtask

  // one clock: model follows the edge, outputs are sampled 5 ns later
  task automatic step(input string tag);
    @(posedge clk);
    if (rst_n) begin
      if (!m_valid && pwr_good) begin
        m_valid = 1'b1;
        m_fs    = {sel3_code == 2'b01, fs_plain};
        m_pair  = strap_pair;
        m_dbg   = strap_dbg;
        m_hw    = sel3_code[1];
      end else if (m_valid && !m_hw && sw_test_entry) begin
        m_sw = 1'b1;
      end
    end
    #5;
    check_all(tag);
    @(negedge clk);
  endtask

  task automatic power_cycle();
    rst_n = 1'b0;
    pwr_good = 1'b0;
    sw_test_entry = 1'b0;
    m_valid = 0; m_hw = 0; m_sw = 0; m_pair = 0; m_dbg = 0; m_fs = '0;
    @(posedge clk); #5;
    check_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rand_straps();
    fs_plain   = W'($urandom);
    strap_pair = 1'($urandom);
    strap_dbg  = 1'($urandom);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd4242);
    @(negedge clk);
    power_cycle();

    // R1 and R9: wiggle everything except power-good, including software entry
    for (int i = 0; i < 4; i++) begin
      rand_straps();
      sel3_code = 2'($urandom);
      test_mode_pin = 1'($urandom);
      sw_test_entry = 1'b1;
      sw_test_sel = 1'($urandom);
      step("R1");
    end
    // capture with entry still high in the capture cycle: ignored (R9)
    sel3_code = 2'b01; strap_pair = 1'b0; strap_dbg = 1'b1; fs_plain = 2'b10;
    pwr_good = 1'b1;
    step("R9");
    sw_test_entry = 1'b0;
    step("R9");
    chk("R9", "mode normal", 8'(mode_code), 8'd1);
    chk("R2", "fs readback", 8'(fs_readback), 8'b110);
    chk("R3", "pair stop", 8'(pair_stop_fn), 8'd1);
    chk("R4", "debug clock", 8'(dbg_clk_fn), 8'd1);
    // R2: later strap changes and power-good toggling are ignored
    for (int i = 0; i < 6; i++) begin
      rand_straps();
      sel3_code = 2'($urandom);
      pwr_good = 1'($urandom);
      step("R2");
    end

    // R5 and R6: hardware test mode
    power_cycle();
    sel3_code = 2'b10; strap_pair = 1'b1; strap_dbg = 1'b0; fs_plain = 2'b01;
    pwr_good = 1'b1;
    step("R5");
    chk("R5", "fsc bit zero", 8'(fs_readback[W]), 8'd0);
    chk("R3", "pair clock", 8'(pair_clk_fn), 8'd1);
    chk("R4", "generic clock", 8'(gen_clk_fn), 8'd1);
    for (int i = 0; i < 8; i++) begin
      test_mode_pin = i[0];
      sw_test_entry = 1'($urandom);
      sw_test_sel = 1'($urandom);
      step("R6");
    end

    // R5: low code gives normal mode and fsc 0
    power_cycle();
    sel3_code = 2'b00; rand_straps(); pwr_good = 1'b1;
    step("R5");
    chk("R5", "normal on low code", 8'(mode_code), 8'd1);

    // R7 and R8: software entry, then clear it
    test_mode_pin = 1'b1; sw_test_sel = 1'b0; sw_test_entry = 1'b1;
    step("R7");
    chk("R7", "hiz via software", 8'(mode_code), 8'd2);
    sw_test_entry = 1'b0;
    for (int i = 0; i < 8; i++) begin
      sw_test_sel = i[1];
      test_mode_pin = i[0];
      step("R8");
    end
    chk("R8", "still refdiv after clear", 8'(mode_code), 8'(sw_test_sel ? 3 : 2));
    power_cycle();
    step("R1");

    // random mix over power cycles
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 39) == 0) power_cycle();
      rand_straps();
      sel3_code = 2'($urandom);
      pwr_good = ($urandom_range(0, 3) != 0);
      test_mode_pin = 1'($urandom);
      sw_test_entry = ($urandom_range(0, 9) == 0);
      sw_test_sel = 1'($urandom);
      step("R2");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule